// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive half of a descriptor-driven DMA engine. Software builds a ring of two-word descriptors in memory, each naming a buffer, and hands the ring's base address to the block. For every frame that arrives on the byte stream, the block claims the next free descriptor, copies the frame bytes into its buffer and then writes back a status word and an ownership flag so that software can collect the buffer.

A frame larger than one buffer runs on into the following descriptors. The first buffer of a frame carries a start flag, the last one carries an end flag and the total length. When the block reaches a descriptor that software has not yet returned, it drops the rest of the frame and pulses a buffer-not-available output. An optional mode holds back the four trailing check bytes of every frame, so that they are neither stored nor counted.

All memory traffic uses one request/acknowledge port. Descriptor reads and status writes are full 32-bit words. Frame bytes are written one at a time on a single byte lane.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: After a synchronous reset `mem_req` and `rx_no_buf` are low, and the first frame goes to the descriptor at `cfg_ring_base`.
- R2: Descriptor k occupies the 32-bit word at ring address + 8k (word 0) and the word after it (word 1). Word 0 bit 0 clear means the descriptor is free. Word 0 bits 31:2 give the word-aligned buffer address.
- R3: Frame bytes are stored in arrival order at buffer address + offset. Each byte is one write with exactly one bit of `mem_be` set, and bytes past the end of the frame are left unchanged.
- R4: After a buffer has been used, word 0 is rewritten with bit 0 set and bits 31:1 unchanged.
- R5: Word 1 is written with bit 14 set in the first buffer of a frame and bit 15 set in the last one. Bits 13:0 hold the total frame length in the last buffer and zero in every other buffer. Bits 31:16 are zero.
- R6: A buffer holds `cfg_buf_units` × 64 bytes. A frame that fills a buffer continues in the next descriptor, and a frame that exactly fills a buffer ends in it.
- R7: After a descriptor whose word 0 bit 1 is set, the next descriptor used is the one at the ring base. Otherwise it is the one 8 bytes further on.
- R8: If the next descriptor's bit 0 is already set, `rx_no_buf` pulses for one cycle, the descriptor is left untouched, the rest of the frame is discarded, and the next frame retries the same descriptor. Buffers already filled by the frame keep their write-back, with no end flag and a length of zero.
- R9: With `cfg_strip_fcs` high, the last 4 bytes of each frame are neither written nor counted in the length.
- R10: Stream bytes that arrive outside a frame (no start marker while idle) are accepted and cause no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ring_base | input | 32 | Byte address of descriptor 0, 8-byte aligned |
| cfg_buf_units | input | UNIT_W | Buffer size in 64-byte units, nonzero |
| cfg_strip_fcs | input | 1 | Drop the trailing 4 check bytes of each frame |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rx_no_buf | output | 1 | One-cycle pulse when a frame meets an owned descriptor |

## Verification
The checker assumes that memory raises `mem_ack` for a single cycle and only while a request is pending. It also assumes that the stream holds a byte steady until it is accepted, that `cfg_buf_units` is nonzero, and that every frame exceeds four bytes when stripping is on. The bench memory model acknowledges each request one cycle after it appears and then drops the acknowledge. Stimulus bytes are driven on the falling edge and held until `in_ready` is seen. Frame lengths are chosen above four bytes, and configuration changes only while the block is idle. Under these conditions the properties check request stability, lane use and the shape of the drop pulse.

// File: rtl/rxr_pkg.sv
// Shared types and descriptor field positions for the receive ring writer.
// Assumes 32-bit descriptor words and byte-addressed memory.
package rxr_pkg;
    localparam int WORD_W   = 32;
    localparam int LEN_W    = 14;
    localparam int OWN_POS  = 0;
    localparam int WRAP_POS = 1;
    localparam int SOF_POS  = 14;
    localparam int EOF_POS  = 15;
    localparam int DESC_BYTES = 8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_DROP, ST_FILL, ST_WBYTE, ST_STAT, ST_OWN
    } rxw_state_e;
endpackage

// File: rtl/rxr_fcs_strip.sv
// Optional trailer remover: with strip_en it delays the stream by HOLD bytes
// and discards the held bytes at end of frame; otherwise it passes through.
// Assumes frames longer than HOLD bytes and strip_en stable within a frame.
module rxr_fcs_strip #(
    parameter int HOLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strip_en,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_sof,
    output logic       out_eof
);
    localparam int FILL_W = $clog2(HOLD + 1);

    logic [7:0]        hold_q [HOLD];
    logic [FILL_W-1:0] fill_q;
    logic              first_q;
    logic              line_full;
    logic              emit_path;
    logic              accept;

    assign line_full = (fill_q == FILL_W'(HOLD));
    assign emit_path = !strip_en || line_full;
    assign in_ready  = !emit_path || out_ready;
    assign accept    = in_valid && in_ready;

    // Output selection: pass-through or oldest held byte.
    always_comb begin
        if (!strip_en) begin
            out_valid = in_valid;
            out_data  = in_data;
            out_sof   = in_sof;
            out_eof   = in_eof;
        end else begin
            out_valid = in_valid && line_full;
            out_data  = hold_q[HOLD-1];
            out_sof   = first_q;
            out_eof   = in_eof;
        end
    end

    // Delay line, fill level and first-byte marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q  <= '0;
            first_q <= 1'b0;
            for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
        end else if (accept && strip_en) begin
            hold_q[0] <= in_data;
            for (int i = 1; i < HOLD; i++) hold_q[i] <= hold_q[i-1];
            if (in_eof)                fill_q <= '0;
            else if (in_sof)           fill_q <= FILL_W'(1);
            else if (!line_full)       fill_q <= fill_q + FILL_W'(1);
            if (in_sof)                first_q <= 1'b1;
            else if (line_full)        first_q <= 1'b0;
        end
    end
endmodule

// File: rtl/rxr_ring_ptr.sv
// Ring pointer: holds the address of the current descriptor, steps by one
// descriptor or returns to base when the used descriptor carried a wrap flag.
// Assumes base is stable while reset is asserted.
module rxr_ring_ptr
    import rxr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] base,
    input  logic              advance,
    input  logic              wrap,
    output logic [WORD_W-1:0] ptr
);
    // Load base on reset, then move on each completed descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n)        ptr <= base;
        else if (advance)  ptr <= wrap ? base : ptr + WORD_W'(DESC_BYTES);
    end
endmodule

// File: rtl/rxr_frame_writer.sv
// Frame writer: claims descriptors, stores frame bytes one lane at a time,
// then writes status and ownership back. Drops a frame on an owned descriptor.
// Assumes a memory that acknowledges each held request with a one-cycle ack.
module rxr_frame_writer
    import rxr_pkg::*;
#(
    parameter int UNIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] buf_units,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [7:0]        s_data,
    input  logic              s_sof,
    input  logic              s_eof,
    input  logic [WORD_W-1:0] desc_ptr,
    output logic              ptr_advance,
    output logic              ptr_wrap,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              no_buf
);
    localparam int OFF_W = UNIT_W + 6;

    rxw_state_e        state;
    logic [WORD_W-1:1] w0_keep;
    logic [OFF_W-1:0]  offset;
    logic [OFF_W-1:0]  buf_size;
    logic [LEN_W-1:0]  frame_len;
    logic              first_buf;
    logic [7:0]        byte_q;
    logic              byte_eof_q;
    logic [WORD_W-1:0] byte_addr;
    logic [WORD_W-1:0] stat_word;
    logic              buf_last;

    assign buf_size  = {buf_units, 6'b0};
    assign byte_addr = {w0_keep[WORD_W-1:2], 2'b00} + WORD_W'(offset);
    assign buf_last  = ((offset + OFF_W'(1)) == buf_size);
    assign stat_word = {16'b0, byte_eof_q, first_buf,
                        byte_eof_q ? frame_len : LEN_W'(0)};

    assign s_ready     = (state == ST_IDLE && !s_sof) || state == ST_DROP
                         || state == ST_FILL;
    assign ptr_advance = (state == ST_OWN) && mem_ack;
    assign ptr_wrap    = w0_keep[WRAP_POS];

    // Memory request decode per state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_ptr;
        mem_be    = 4'hF;
        mem_wdata = '0;
        unique case (state)
            ST_FETCH: mem_req = 1'b1;
            ST_WBYTE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {byte_addr[WORD_W-1:2], 2'b00};
                mem_be    = 4'b0001 << byte_addr[1:0];
                mem_wdata = {4{byte_q}};
            end
            ST_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_ptr + WORD_W'(4);
                mem_wdata = stat_word;
            end
            ST_OWN: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = {w0_keep, 1'b1};
            end
            default: ;
        endcase
    end

    // Frame sequencing: fetch, fill, status, ownership, drop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            w0_keep    <= '0;
            offset     <= '0;
            frame_len  <= '0;
            first_buf  <= 1'b0;
            byte_q     <= '0;
            byte_eof_q <= 1'b0;
            no_buf     <= 1'b0;
        end else begin
            no_buf <= 1'b0;
            unique case (state)
                ST_IDLE: if (s_valid && s_sof) begin
                    state     <= ST_FETCH;
                    frame_len <= '0;
                    first_buf <= 1'b1;
                end
                ST_FETCH: if (mem_ack) begin
                    if (mem_rdata[OWN_POS]) begin
                        no_buf <= 1'b1;
                        state  <= ST_DROP;
                    end else begin
                        w0_keep <= mem_rdata[WORD_W-1:1];
                        offset  <= '0;
                        state   <= ST_FILL;
                    end
                end
                ST_DROP: if (s_valid && s_eof) state <= ST_IDLE;
                ST_FILL: if (s_valid) begin
                    byte_q     <= s_data;
                    byte_eof_q <= s_eof;
                    state      <= ST_WBYTE;
                end
                ST_WBYTE: if (mem_ack) begin
                    offset    <= offset + OFF_W'(1);
                    frame_len <= frame_len + LEN_W'(1);
                    state     <= (byte_eof_q || buf_last) ? ST_STAT : ST_FILL;
                end
                ST_STAT: if (mem_ack) state <= ST_OWN;
                ST_OWN: if (mem_ack) begin
                    first_buf <= 1'b0;
                    state     <= byte_eof_q ? ST_IDLE : ST_FETCH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_desc_ring_writer.sv
// Receive descriptor ring writer top: trailer remover, frame writer and ring
// pointer joined. Assumes an 8-byte aligned ring base and nonzero buffer units.
module rx_desc_ring_writer
    import rxr_pkg::*;
#(
    parameter int UNIT_W     = 8,
    parameter int HOLD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_ring_base,
    input  logic [UNIT_W-1:0] cfg_buf_units,
    input  logic              cfg_strip_fcs,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              rx_no_buf
);
    logic              st_valid;
    logic              st_ready;
    logic [7:0]        st_data;
    logic              st_sof;
    logic              st_eof;
    logic              adv;
    logic              wrap;
    logic [WORD_W-1:0] ptr;

    rxr_fcs_strip #(.HOLD(HOLD_BYTES)) u_strip (
        .clk       (clk),
        .rst_n     (rst_n),
        .strip_en  (cfg_strip_fcs),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .out_valid (st_valid),
        .out_ready (st_ready),
        .out_data  (st_data),
        .out_sof   (st_sof),
        .out_eof   (st_eof)
    );

    rxr_frame_writer #(.UNIT_W(UNIT_W)) u_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .buf_units   (cfg_buf_units),
        .s_valid     (st_valid),
        .s_ready     (st_ready),
        .s_data      (st_data),
        .s_sof       (st_sof),
        .s_eof       (st_eof),
        .desc_ptr    (ptr),
        .ptr_advance (adv),
        .ptr_wrap    (wrap),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_be      (mem_be),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .no_buf      (rx_no_buf)
    );

    rxr_ring_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .base    (cfg_ring_base),
        .advance (adv),
        .wrap    (wrap),
        .ptr     (ptr)
    );
endmodule

// File: rtl/rx_desc_ring_writer_chk.sv
// Property checker for the receive ring writer, bound to the top module.
// Assumes memory acknowledges only pending requests, for one cycle.
module rx_desc_ring_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic        mem_ack,
    input logic        rx_no_buf
);
    // R2: a request waits, unchanged, for its acknowledge
    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R2: every access is word aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R3: writes use one byte lane or the full word
    a_r3_lane_use: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF));

    // R8: the drop indication is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_no_buf |=> !rx_no_buf);

    // R8: a dropped frame touches no memory
    a_r8_quiet_drop: assert property (@(posedge clk) disable iff (!rst_n)
        rx_no_buf |-> !mem_req);
endmodule

bind rx_desc_ring_writer rx_desc_ring_writer_chk u_chk (.*);

// File: tb/rx_desc_ring_writer_bench.sv
module rx_desc_ring_writer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ring_base = 32'h100;
    logic [7:0]  cfg_buf_units = 8'd1;
    logic        cfg_strip_fcs = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = 8'd0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = 32'd0;
    logic        rx_no_buf;

    logic [31:0] mem [0:1023];
    int checks = 0;
    int errors = 0;
    int nobuf_cnt = 0;
    int wr_cnt = 0;
    int exp_idx = 0;

    // vector: frame length, strip flag
    localparam int VEC [6][2] = '{'{20, 0}, '{64, 0}, '{65, 0},
                                  '{150, 0}, '{30, 1}, '{68, 1}};

    always #2 clk = ~clk;

    rx_desc_ring_writer u_rx_desc_ring_writer (.*);

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                wr_cnt++;
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
        if (rx_no_buf) nobuf_cnt++;
    end

    function automatic int dw(int k);
        return 64 + 2 * (k % 4);
    endfunction
    function automatic int ba(int k);
        return 32'h400 + (k % 4) * 256;
    endfunction
    function automatic int rd_byte(int a);
        return (mem[(a >> 2) & 1023] >> (8 * (a & 3))) & 8'hFF;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic prep_ring();
        for (int k = 0; k < 4; k++) begin
            mem[dw(k)]     = ba(k) | (k == 3 ? 2 : 0);
            mem[dw(k) + 1] = 32'hFFFF_FFFF;
            for (int w = 0; w < 64; w++) mem[(ba(k) >> 2) + w] = 32'hEEEE_EEEE;
        end
    endtask

    task automatic push(int d, bit s, bit e);
        bit acc;
        in_valid = 1'b1; in_data = d[7:0]; in_sof = s; in_eof = e;
        forever begin
            #1 acc = in_ready;
            @(posedge clk);
            if (acc) break;
            @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic send(int n, int seed);
        for (int i = 0; i < n; i++) push(seed + i, i == 0, i == n - 1);
    endtask

    task automatic quiet();
        int q = 0;
        while (q < 12) begin
            @(negedge clk);
            if (mem_req) q = 0; else q++;
        end
    endtask

    // check a delivered frame of n stored bytes starting at descriptor exp_idx
    task automatic check_frame(int n, int seed, int bsz, bit strip);
        int nbuf = (n + bsz - 1) / bsz;
        int bad = 0;
        int k;
        logic [31:0] e0, e1;
        for (int b = 0; b < nbuf; b++) begin
            k = exp_idx + b;
            e0 = ba(k) | ((k % 4) == 3 ? 2 : 0) | 1;
            chk(mem[dw(k)] == e0, "R4/R7 owner word", mem[dw(k)], e0);
            e1 = (b == 0 ? 32'h4000 : 0) | (b == nbuf - 1 ? (32'h8000 | n) : 0);
            chk(mem[dw(k) + 1] == e1, "R5 status word", mem[dw(k) + 1], e1);
        end
        for (int i = 0; i < n; i++)
            if (rd_byte(ba(exp_idx + i / bsz) + i % bsz) != ((seed + i) & 8'hFF)) bad++;
        chk(bad == 0, "R3/R6 buffer data", bad, 0);
        if (n % bsz != 0)
            chk(rd_byte(ba(exp_idx + nbuf - 1) + n % bsz) == 8'hEE,
                strip ? "R9 trailer not stored" : "R3 past end untouched",
                rd_byte(ba(exp_idx + nbuf - 1) + n % bsz), 8'hEE);
        if (nbuf < 4)
            chk(mem[dw(exp_idx + nbuf)][0] == 1'b0, "R7 next descriptor untouched",
                mem[dw(exp_idx + nbuf)], ba(exp_idx + nbuf));
        exp_idx = (exp_idx + nbuf) % 4;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n0, wbefore, nb0;
        logic [31:0] s0, s1;
        for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(mem_req == 1'b0, "R1 no request after reset", mem_req, 0);
        chk(rx_no_buf == 1'b0, "R1 no drop after reset", rx_no_buf, 0);

        // table of frames (R1 first lands on descriptor 0, R6 split, R7 wrap)
        for (int v = 0; v < 6; v++) begin
            prep_ring();
            cfg_strip_fcs = VEC[v][1][0];
            send(VEC[v][0], v * 37);
            quiet();
            check_frame(VEC[v][0] - (VEC[v][1] != 0 ? 4 : 0), v * 37, 64, VEC[v][1] != 0);
        end
        cfg_strip_fcs = 1'b0;

        // R10: bytes outside a frame are ignored
        prep_ring();
        wbefore = wr_cnt;
        for (int i = 0; i < 3; i++) push(i, 1'b0, 1'b0);
        quiet();
        chk(wr_cnt == wbefore, "R10 stray bytes no writes", wr_cnt, wbefore);

        // R8: owned descriptor drops the whole frame
        prep_ring();
        mem[dw(exp_idx)] = mem[dw(exp_idx)] | 1;
        s0 = mem[dw(exp_idx)]; s1 = mem[dw(exp_idx) + 1];
        nb0 = nobuf_cnt;
        send(40, 5);
        quiet();
        chk(nobuf_cnt == nb0 + 1, "R8 drop pulse", nobuf_cnt, nb0 + 1);
        chk(mem[dw(exp_idx)] == s0 && mem[dw(exp_idx) + 1] == s1,
            "R8 owned descriptor untouched", mem[dw(exp_idx) + 1], s1);
        mem[dw(exp_idx)] = s0 & ~32'h1;
        send(10, 9);
        quiet();
        check_frame(10, 9, 64, 1'b0);

        // R8: drop in mid-frame keeps the first buffer without end flag
        prep_ring();
        mem[dw(exp_idx + 1)] = mem[dw(exp_idx + 1)] | 1;
        nb0 = nobuf_cnt;
        send(100, 11);
        quiet();
        chk(nobuf_cnt == nb0 + 1, "R8 mid-frame drop pulse", nobuf_cnt, nb0 + 1);
        chk(mem[dw(exp_idx) + 1] == 32'h4000, "R8 partial buffer status",
            mem[dw(exp_idx) + 1], 32'h4000);
        exp_idx = (exp_idx + 1) % 4;
        mem[dw(exp_idx)] = mem[dw(exp_idx)] & ~32'h1;
        send(12, 3);
        quiet();
        check_frame(12, 3, 64, 1'b0);

        // R6: two units give 128-byte buffers
        prep_ring();
        cfg_buf_units = 8'd2;
        n0 = 100;
        send(n0, 21);
        quiet();
        check_frame(n0, 21, 128, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule